// File: doc/BRIEF.md
# Flash Controller Reset and Clock-Idle Control

This unit sits beside the core of a flash memory interface and gives software three controls over it through a small 32-bit register bus. Software can start a core reset that runs independently of the chip reset pin, and a status bit shows when that reset has finished. An idle setting lets the core clock stop whenever nothing is happening. A test window gives direct word-wide access to the core's internal FIFO.

The unit drives an active-high soft reset to the core and a clock-enable request to an external gating cell. In test-map mode it turns accesses to the window register into FIFO write and read strobes, and passes the data straight through. The core keeps its own FIFO and busy flag and clears both while the soft reset is asserted.

Register map, by word address on `bus_addr`: 0 = configuration (bit 0 idle mode, bit 1 soft-reset trigger), 1 = status (bit 0 reset complete), 2 = test control (bit 0 map enable), 3 = FIFO window (all 32 bits). An access is one cycle with `bus_sel` high. Read data is presented on `bus_rdata` in the cycle after the read and is zero in every other cycle.

Top module: `fsc_sysctl`

## Requirements
- R1: While `rst_n` is low, and right after it is released, the configuration and test-control registers hold 0, `core_srst` is low, `bus_rdata` is 0 and `clk_en` is high.
- R2: A write to word 0 with bit 1 set raises `core_srst` on the next cycle and holds it high for exactly `RST_CYCLES` (default 8) cycles. Bit 1 of word 0 always reads back 0.
- R3: Status word 1 bit 0 reads 0 from the cycle after the trigger write until `core_srst` falls, and reads 1 starting one cycle after `core_srst` has fallen. Bits 31:1 read 0, and writes to word 1 change nothing.
- R4: After `rst_n` is released, status bit 0 reads 0 for one cycle and then reads 1.
- R5: While idle mode (word 0 bit 0) is 0, `clk_en` is high in every cycle.
- R6: While idle mode is 1, `clk_en` is high exactly in cycles where `bus_sel`, `core_busy` or `core_srst` is high.
- R7: While `core_srst` is high, `clk_en` is high whatever the idle mode.
- R8: With map enable (word 2 bit 0) set, a write to word 3 pulses `fifo_wr` in that cycle with `fifo_wdata` equal to the bus data. A read of word 3 pulses `fifo_rd` in that cycle and returns the `fifo_rdata` sampled in that cycle.
- R9: With map enable clear, accesses to word 3 never assert `fifo_wr` or `fifo_rd`, and a read of word 3 returns 0x00000000.
- R10: Writes to reserved bits of words 0 and 2 are ignored and those bits read 0. A soft reset leaves idle mode and map enable unchanged.
- R11: A second trigger write while `core_srst` is high restarts the count, so `core_srst` stays high for `RST_CYCLES` cycles after the last trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| core_busy | input | 1 | Core has an operation in progress |
| core_srst | output | 1 | Soft reset to the core, active high |
| clk_en | output | 1 | Core clock-enable request |
| fifo_wr | output | 1 | Direct FIFO write strobe |
| fifo_rd | output | 1 | Direct FIFO read strobe |
| fifo_wdata | output | 32 | Direct FIFO write data |
| fifo_rdata | input | 32 | Current FIFO head word from the core |

## Verification
A wrong reset counter shows as a `core_srst` pulse that is one cycle too long or too short, or as a status bit that turns 1 while `core_srst` is still high. The per-cycle comparison catches either on the first edge where the two disagree. A stuck idle-mode or map bit shows at once on `clk_en` in a quiet cycle, or as a FIFO strobe during a refused window access. A corrupted read path shows one cycle after the offending read, because `bus_rdata` is compared in every cycle, including cycles with no read, where it must be zero.

// File: rtl/fsc_sysctl_pkg.sv
package fsc_sysctl_pkg;

    localparam int unsigned REG_W = 32;

    // Word addresses; the window decode depends on these values.
    typedef enum logic [1:0] {
        RA_CFG  = 2'd0,
        RA_STAT = 2'd1,
        RA_TEST = 2'd2,
        RA_WIN  = 2'd3
    } reg_sel_e;

    localparam int unsigned CFG_IDLE_BIT = 0;
    localparam int unsigned CFG_SRST_BIT = 1;
    localparam int unsigned TEST_MAP_BIT = 0;

    typedef struct packed {
        logic             auto_idle;
        logic             test_map;
        logic [REG_W-1:0] rdata;
    } regs_state_t;

endpackage

// File: rtl/fsc_sysctl_srst.sv
module fsc_sysctl_srst #(
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } srst_state_t;

    srst_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt  = CNT_LOAD;
            st_d.done = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
    assign done   = st_q.done;

    // R2: a trigger holds the core in reset on the next cycle
    assert_start_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && !done));

    // R3: completion never reported while reset is asserted
    assert_busy_not_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !done);

    // R3: completion follows the release by one cycle
    assert_done_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active) && !start) |=> done);

endmodule

// File: rtl/fsc_sysctl_clkreq.sv
module fsc_sysctl_clkreq (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_idle,
    input  logic bus_sel,
    input  logic core_busy,
    input  logic srst_active,
    output logic clk_en
);
    logic wake;

    always_comb begin
        wake   = bus_sel | core_busy | srst_active;
        clk_en = auto_idle ? wake : 1'b1;
    end

    // R5: free-running clock when idle mode is off
    assert_free_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_idle |-> clk_en);

    // R6: gated off when idle mode is on and nothing is pending
    assert_idle_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_idle && !bus_sel && !core_busy && !srst_active) |-> !clk_en);

    // R7: soft reset always has a clock
    assert_srst_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        srst_active |-> clk_en);

endmodule

// File: rtl/fsc_sysctl_regs.sv
module fsc_sysctl_regs
    import fsc_sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        wr_ctl,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              srst_done,
    input  logic [REG_W-1:0]  fifo_rdata,
    output logic              fifo_wr,
    output logic              fifo_rd,
    output logic              auto_idle,
    output logic              test_map,
    output logic              srst_start
);
    regs_state_t st_d, st_q;
    reg_sel_e    sel;
    logic        wr, rd;

    always_comb begin
        sel  = reg_sel_e'(bus_addr[1:0]);
        wr   = bus_sel & bus_we;
        rd   = bus_sel & ~bus_we;
        st_d = st_q;
        st_d.rdata = '0;

        srst_start = wr && (sel == RA_CFG) && wr_ctl[CFG_SRST_BIT];
        fifo_wr    = wr && (sel == RA_WIN) && st_q.test_map;
        fifo_rd    = rd && (sel == RA_WIN) && st_q.test_map;

        if (wr && sel == RA_CFG)  st_d.auto_idle = wr_ctl[CFG_IDLE_BIT];
        if (wr && sel == RA_TEST) st_d.test_map  = wr_ctl[TEST_MAP_BIT];

        if (rd) begin
            unique case (sel)
                RA_CFG:  st_d.rdata[CFG_IDLE_BIT] = st_q.auto_idle;
                RA_STAT: st_d.rdata[0]            = srst_done;
                RA_TEST: st_d.rdata[TEST_MAP_BIT] = st_q.test_map;
                RA_WIN:  if (st_q.test_map) st_d.rdata = fifo_rdata;
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign auto_idle = st_q.auto_idle;
    assign test_map  = st_q.test_map;

    // R9: window refused without map enable
    assert_win_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_map |-> !(fifo_wr || fifo_rd));

    // R10: read data is zero outside the cycle after a read
    assert_rdata_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && !bus_we) |-> (bus_rdata == '0));

    // R10: control bits move only on a bus write
    assert_ctl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_we) |=> ($stable(auto_idle) && $stable(test_map)));

endmodule

// File: rtl/fsc_sysctl.sv
module fsc_sysctl
    import fsc_sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W     = 2,
    parameter int unsigned RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              core_busy,
    output logic              core_srst,
    output logic              clk_en,
    output logic              fifo_wr,
    output logic              fifo_rd,
    output logic [REG_W-1:0]  fifo_wdata,
    input  logic [REG_W-1:0]  fifo_rdata
);
    logic srst_start, srst_active, srst_done;
    logic auto_idle, test_map;

    fsc_sysctl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .wr_ctl     (bus_wdata[1:0]),
        .bus_rdata  (bus_rdata),
        .srst_done  (srst_done),
        .fifo_rdata (fifo_rdata),
        .fifo_wr    (fifo_wr),
        .fifo_rd    (fifo_rd),
        .auto_idle  (auto_idle),
        .test_map   (test_map),
        .srst_start (srst_start)
    );

    fsc_sysctl_srst #(.RST_CYCLES(RST_CYCLES)) u_srst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (srst_start),
        .active (srst_active),
        .done   (srst_done)
    );

    fsc_sysctl_clkreq u_clkreq (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_idle   (auto_idle),
        .bus_sel     (bus_sel),
        .core_busy   (core_busy),
        .srst_active (srst_active),
        .clk_en      (clk_en)
    );

    assign core_srst  = srst_active;
    assign fifo_wdata = bus_wdata;

    // R10: soft reset does not disturb the mode bits
    assert_srst_keeps_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_srst && !(bus_sel && bus_we)) |=> ($stable(auto_idle) && $stable(test_map)));

endmodule

// File: tb/fsc_sysctl_tb.sv
module fsc_sysctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RSTC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0, core_busy = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, fifo_rdata = '0;
    logic [31:0] bus_rdata, fifo_wdata;
    logic        core_srst, clk_en, fifo_wr, fifo_rd;

    int n_vec = 0, n_bad = 0, n_cyc = 0;
    bit finished = 0;

    // reference model state
    int    m_ai = 0, m_map = 0, m_cnt = 0, m_done = 0;
    logic [31:0] m_rdata = '0;
    string m_rtag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    fsc_sysctl #(.ADDR_W(2), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_busy(core_busy), .core_srst(core_srst), .clk_en(clk_en),
        .fifo_wr(fifo_wr), .fifo_rd(fifo_rd), .fifo_wdata(fifo_wdata),
        .fifo_rdata(fifo_rdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, n_cyc);
        end
    endtask

    task automatic compare_all();
        logic e_wr, e_rd, e_clk;
        string ctag;
        e_wr  = bus_sel && bus_we && bus_addr == 2'd3 && m_map != 0;
        e_rd  = bus_sel && !bus_we && bus_addr == 2'd3 && m_map != 0;
        e_clk = (m_ai == 0) || bus_sel || core_busy || (m_cnt != 0);
        ctag  = (m_cnt != 0) ? "R7" : ((m_ai == 0) ? "R5" : "R6");
        chk(m_cnt != 0 ? "R2" : "R11", "core_srst", {31'b0, core_srst}, {31'b0, m_cnt != 0});
        chk(ctag, "clk_en", {31'b0, clk_en}, {31'b0, e_clk});
        chk(m_map != 0 ? "R8" : "R9", "fifo_wr", {31'b0, fifo_wr}, {31'b0, e_wr});
        chk(m_map != 0 ? "R8" : "R9", "fifo_rd", {31'b0, fifo_rd}, {31'b0, e_rd});
        if (e_wr) chk("R8", "fifo_wdata", fifo_wdata, bus_wdata);
        chk(m_rtag, "bus_rdata", bus_rdata, m_rdata);
    endtask

    task automatic cyc(input logic s, input logic w, input logic [1:0] a,
                       input logic [31:0] d, input logic b);
        logic wr, rd, start;
        int n_ai, n_map, n_cnt, n_done;
        logic [31:0] n_rd;
        bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; core_busy = b;
        fifo_rdata = 32'hC0DE_0000 + n_cyc;
        #1;
        compare_all();
        wr = s && w; rd = s && !w;
        start = wr && a == 2'd0 && d[1];
        n_rd = '0;
        if (rd) begin
            case (a)
                2'd0: begin n_rd[0] = (m_ai != 0);   m_rtag = "R10"; end
                2'd1: begin n_rd[0] = (m_done != 0); m_rtag = "R3"; end
                2'd2: begin n_rd[0] = (m_map != 0);  m_rtag = "R10"; end
                default: begin
                    n_rd = (m_map != 0) ? fifo_rdata : 32'h0;
                    m_rtag = (m_map != 0) ? "R8" : "R9";
                end
            endcase
        end else m_rtag = "R10";
        n_ai   = (wr && a == 2'd0) ? int'(d[0]) : m_ai;
        n_map  = (wr && a == 2'd2) ? int'(d[0]) : m_map;
        n_cnt  = start ? RSTC : (m_cnt > 0 ? m_cnt - 1 : 0);
        n_done = start ? 0 : (m_cnt == 0 ? 1 : m_done);
        @(posedge clk);
        m_ai = n_ai; m_map = n_map; m_cnt = n_cnt; m_done = n_done; m_rdata = n_rd;
        n_cyc++;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic b);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 32'h0, b);
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        bus_sel = 0; bus_we = 0; core_busy = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R1: reset values at the ports
            chk("R1", "rst core_srst", {31'b0, core_srst}, 32'h0);
            chk("R1", "rst clk_en", {31'b0, clk_en}, 32'h1);
            chk("R1", "rst bus_rdata", bus_rdata, 32'h0);
        end
        m_ai = 0; m_map = 0; m_cnt = 0; m_done = 0; m_rdata = '0; m_rtag = "R1";
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        hw_reset();
        // R4: status 0 in first cycle after release, then 1
        cyc(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        cyc(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        cyc(1'b1, 1'b0, 2'd0, 32'h0, 1'b0);   // R1 config reads 0
        cyc(1'b1, 1'b0, 2'd2, 32'h0, 1'b0);
        // R9: window refused with map clear
        cyc(1'b1, 1'b1, 2'd3, 32'h1234_5678, 1'b0);
        cyc(1'b1, 1'b0, 2'd3, 32'h0, 1'b0);
        idle(2, 1'b1);
        // R10: reserved bits set, idle on, trigger bit clear
        cyc(1'b1, 1'b1, 2'd0, 32'hFFFF_FFFD, 1'b0);
        cyc(1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
        // R6: gating follows sel and busy
        idle(3, 1'b0);
        idle(2, 1'b1);
        cyc(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        idle(2, 1'b0);
        // R8: map on, window traffic
        cyc(1'b1, 1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0);
        cyc(1'b1, 1'b0, 2'd2, 32'h0, 1'b0);
        cyc(1'b1, 1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0);
        cyc(1'b1, 1'b1, 2'd3, 32'h0BAD_F00D, 1'b1);
        cyc(1'b1, 1'b0, 2'd3, 32'h0, 1'b0);
        cyc(1'b1, 1'b0, 2'd3, 32'h0, 1'b0);
        idle(1, 1'b0);
        // R2/R3/R7: soft reset with idle mode on, status polled throughout
        cyc(1'b1, 1'b1, 2'd0, 32'h0000_0003, 1'b0);
        for (int i = 0; i < RSTC + 3; i++) cyc(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        cyc(1'b1, 1'b0, 2'd0, 32'h0, 1'b0);
        cyc(1'b1, 1'b0, 2'd2, 32'h0, 1'b0);   // R10 modes survive
        idle(2, 1'b0);
        // R11: restart mid-sequence, quiet bus so clk_en comes only from reset
        cyc(1'b1, 1'b1, 2'd0, 32'h0000_0003, 1'b0);
        idle(4, 1'b0);
        cyc(1'b1, 1'b1, 2'd0, 32'h0000_0003, 1'b0);
        idle(RSTC + 3, 1'b0);
        cyc(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        // R3: status not writable
        cyc(1'b1, 1'b1, 2'd1, 32'h0000_0000, 1'b0);
        cyc(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        // R5: idle mode off, free running
        cyc(1'b1, 1'b1, 2'd0, 32'h0, 1'b0);
        idle(3, 1'b0);
        cyc(1'b1, 1'b1, 2'd0, 32'h0000_0002, 1'b0);
        idle(RSTC + 2, 1'b0);
        // R4 again after a later hardware reset
        hw_reset();
        cyc(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        cyc(1'b1, 1'b0, 2'd1, 32'h0, 1'b0);
        cyc(1'b1, 1'b0, 2'd2, 32'h0, 1'b0);
        idle(2, 1'b0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule